// File: doc/BRIEF.md
# Block I/O Transfer Sequencer

This block moves a run of bytes between a 16-bit-addressed I/O space and memory. A command gives a direction (port to memory, or memory to port), an address step direction (up or down), a single or repeating mode, a starting memory pointer and a starting port word. The upper byte of the port word is also the transfer counter. The lower byte selects the port and does not change.

Each transfer has two handshakes, one on the I/O side and one on the memory side. Only one of them is active at a time. Both sides use valid/ready. The sequencer raises `*_valid` and keeps the address, the write flag and the write data steady until it samples `*_ready` high on a clock edge. A low ready stalls the sequence for as many cycles as the responder needs. Read data is taken in the cycle of the handshake.

In repeat mode the block runs transfers until the counter reaches zero. It inserts `EXTRA_CYCLES` quiet cycles (default 5) between consecutive transfers. `EXTRA_CYCLES` must be at least 1. When the command finishes, the final pointer, the final port word and the flag byte are shown on the outputs, and `done` pulses for one cycle.

Top module: `blk_io_seq`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while `busy` is low, so a `cmd_valid` raised during a run has no effect on that run.
- R2: In the port-to-memory direction (`cmd_to_port`=0), a transfer first reads the port at {B,C}, using B before it is decremented. It then writes that byte to memory at HL.
- R3: In the memory-to-port direction (`cmd_to_port`=1), a transfer first reads memory at HL. It then writes that byte to the port at {B-1,C}, so the port address carries the counter after its decrement.
- R4: HL changes by exactly 1 on every memory handshake: it decrements when `cmd_down`=1 and increments otherwise, wrapping modulo 2^16.
- R5: Each transfer decrements only B, modulo 256. C never changes. In repeat mode a starting B of 0 gives 256 transfers.
- R6: Each transfer replaces the whole flag byte with 0x02 (bit 1 set), plus 0x40 (bit 6) when B has just become 0. A repeat run therefore ends with the flags exactly 0x42.
- R7: In repeat mode, exactly `EXTRA_CYCLES` cycles with both strobes low separate the last handshake of one transfer from the first handshake of the next, when the responders are ready. Inside a transfer there are no idle cycles.
- R8: While a strobe is high and its ready is low, the strobe stays high and its address, write flag and write data do not change.
- R9: `done` pulses for one cycle, one cycle after the final handshake. A single-step command performs exactly one transfer, whatever the value of B.
- R10: The I/O strobe and the memory strobe are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_to_port | input | 1 | 1: memory to port, 0: port to memory |
| cmd_down | input | 1 | 1: HL decrements, 0: HL increments |
| cmd_repeat | input | 1 | 1: repeat until B is zero |
| cmd_hl | input | 16 | Starting memory pointer |
| cmd_bc | input | 16 | Starting port word {B,C} |
| io_valid | output | 1 | I/O strobe |
| io_write | output | 1 | I/O direction, 1 = write |
| io_addr | output | 16 | I/O port address |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data |
| io_ready | input | 1 | I/O side ready |
| mem_valid | output | 1 | Memory strobe |
| mem_write | output | 1 | Memory direction, 1 = write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory side ready |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| hl_out | output | 16 | Current memory pointer |
| bc_out | output | 16 | Current port word |
| flags_out | output | 8 | Flag byte |

## Verification
The hardest case to reach is counter wrap-around. A repeat run that starts with B at zero must run 256 transfers, and every one of them must carry the correct counter in its port address and the exact quiet gap. The bench starts a command with a zero counter and lets it run to completion. Pseudo-random ready patterns stall both sides throughout. A scoreboard checks every handshake along the way, including the gap before each one. Other runs reach HL wrap in both step directions and a command raised while the block is busy.

// File: rtl/bio_pkg.sv
package bio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_GAP    = 2'd3
  } bio_state_e;
endpackage

// File: rtl/bio_ctrl.sv
module bio_ctrl
  import bio_pkg::*;
#(
  parameter int EXTRA_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       hs,
  input  logic       rep,
  input  logic       last,
  output bio_state_e state,
  output logic       done
);
  localparam int GAP_W = (EXTRA_CYCLES > 1) ? $clog2(EXTRA_CYCLES + 1) : 1;

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      gap_cnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE:  if (cmd_valid) state <= ST_FIRST;
        ST_FIRST: if (hs) state <= ST_SECOND;
        ST_SECOND: begin
          if (hs) begin
            if (!rep || last) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state   <= ST_GAP;
              gap_cnt <= GAP_W'(EXTRA_CYCLES - 1);
            end
          end
        end
        default: begin
          if (gap_cnt == '0) state <= ST_FIRST;
          else gap_cnt <= gap_cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bio_regs.sv
module bio_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int N_BIT  = 1,
  parameter int Z_BIT  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                to_port_in,
  input  logic                down_in,
  input  logic                rep_in,
  input  logic [ADDR_W-1:0]   hl_in,
  input  logic [ADDR_W-1:0]   bc_in,
  input  logic                cap,
  input  logic [DATA_W-1:0]   cap_data,
  input  logic                step,
  output logic [ADDR_W-1:0]   hl,
  output logic [CNT_W-1:0]    b,
  output logic [ADDR_W-CNT_W-1:0] c,
  output logic [DATA_W-1:0]   data,
  output logic [FLAG_W-1:0]   flags,
  output logic                to_port,
  output logic                down,
  output logic                rep,
  output logic                last
);
  localparam int C_W = ADDR_W - CNT_W;

  logic [FLAG_W-1:0] flag_nxt;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    if (i == N_BIT) begin : g_n
      assign flag_nxt[i] = 1'b1;
    end else if (i == Z_BIT) begin : g_z
      assign flag_nxt[i] = (b == CNT_W'(1));
    end else begin : g_zero
      assign flag_nxt[i] = 1'b0;
    end
  end

  // Memory-to-port transfers have already decremented B by the second phase.
  assign last = to_port ? (b == '0) : (b == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hl      <= '0;
      b       <= '0;
      c       <= '0;
      data    <= '0;
      flags   <= '0;
      to_port <= 1'b0;
      down    <= 1'b0;
      rep     <= 1'b0;
    end else begin
      if (load) begin
        hl      <= hl_in;
        b       <= bc_in[ADDR_W-1:C_W];
        c       <= bc_in[C_W-1:0];
        to_port <= to_port_in;
        down    <= down_in;
        rep     <= rep_in;
      end
      if (cap) data <= cap_data;
      if (step) begin
        hl    <= down ? hl - ADDR_W'(1) : hl + ADDR_W'(1);
        b     <= b - CNT_W'(1);
        flags <= flag_nxt;
      end
    end
  end
endmodule

// File: rtl/blk_io_seq.sv
module blk_io_seq
  import bio_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CNT_W        = 8,
  parameter int DATA_W       = 8,
  parameter int FLAG_W       = 8,
  parameter int N_BIT        = 1,
  parameter int Z_BIT        = 6,
  parameter int EXTRA_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_to_port,
  input  logic              cmd_down,
  input  logic              cmd_repeat,
  input  logic [ADDR_W-1:0] cmd_hl,
  input  logic [ADDR_W-1:0] cmd_bc,
  output logic              io_valid,
  output logic              io_write,
  output logic [ADDR_W-1:0] io_addr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic              io_ready,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] hl_out,
  output logic [ADDR_W-1:0] bc_out,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int C_W = ADDR_W - CNT_W;

  bio_state_e        state;
  logic              mode_to_port, mode_down, mode_rep, last;
  logic [CNT_W-1:0]  b_q;
  logic [C_W-1:0]    c_q;
  logic [DATA_W-1:0] data_q;
  logic              io_hs, mem_hs, hs, load, cap;
  logic [DATA_W-1:0] cap_data;

  assign busy      = (state != ST_IDLE);
  assign cmd_ready = !busy;
  assign load      = cmd_valid && cmd_ready;

  assign io_valid  = (state == ST_FIRST  && !mode_to_port) ||
                     (state == ST_SECOND &&  mode_to_port);
  assign mem_valid = (state == ST_FIRST  &&  mode_to_port) ||
                     (state == ST_SECOND && !mode_to_port);
  assign io_write  = mode_to_port;
  assign mem_write = !mode_to_port;
  assign io_addr   = {b_q, c_q};
  assign mem_addr  = hl_out;
  assign io_wdata  = data_q;
  assign mem_wdata = data_q;
  assign bc_out    = {b_q, c_q};

  assign io_hs    = io_valid && io_ready;
  assign mem_hs   = mem_valid && mem_ready;
  assign hs       = io_hs || mem_hs;
  assign cap      = (state == ST_FIRST) && hs;
  assign cap_data = mode_to_port ? mem_rdata : io_rdata;

  bio_ctrl #(.EXTRA_CYCLES(EXTRA_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .hs        (hs),
    .rep       (mode_rep),
    .last      (last),
    .state     (state),
    .done      (done)
  );

  bio_regs #(
    .ADDR_W (ADDR_W), .CNT_W (CNT_W), .DATA_W (DATA_W),
    .FLAG_W (FLAG_W), .N_BIT (N_BIT), .Z_BIT (Z_BIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .to_port_in (cmd_to_port),
    .down_in    (cmd_down),
    .rep_in     (cmd_repeat),
    .hl_in      (cmd_hl),
    .bc_in      (cmd_bc),
    .cap        (cap),
    .cap_data   (cap_data),
    .step       (mem_hs),
    .hl         (hl_out),
    .b          (b_q),
    .c          (c_q),
    .data       (data_q),
    .flags      (flags_out),
    .to_port    (mode_to_port),
    .down       (mode_down),
    .rep        (mode_rep),
    .last       (last)
  );
endmodule

// File: rtl/bio_seq_checker.sv
module bio_seq_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int N_BIT  = 1,
  parameter int Z_BIT  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              busy,
  input logic              done,
  input logic              io_valid,
  input logic              io_ready,
  input logic              io_write,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_wdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] hl_out,
  input logic [ADDR_W-1:0] bc_out,
  input logic [FLAG_W-1:0] flags_out,
  input logic              mode_down,
  input logic              mode_rep
);
  localparam int C_W = ADDR_W - CNT_W;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);

  p_hl_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=>
      hl_out == (mode_down ? $past(hl_out) - ADDR_W'(1) : $past(hl_out) + ADDR_W'(1)));

  p_c_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bc_out[C_W-1:0]));

  p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[N_BIT] && (flags_out[Z_BIT] == (bc_out[ADDR_W-1:C_W] == '0)));

  p_rep_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_rep |-> bc_out[ADDR_W-1:C_W] == '0);

  p_io_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid && !io_ready |=> io_valid && $stable(io_addr) && $stable(io_write) && $stable(io_wdata));

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_valid && mem_valid));
endmodule

bind blk_io_seq bio_seq_checker #(
  .ADDR_W (ADDR_W), .CNT_W (CNT_W), .DATA_W (DATA_W),
  .FLAG_W (FLAG_W), .N_BIT (N_BIT), .Z_BIT (Z_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .io_valid  (io_valid),
  .io_ready  (io_ready),
  .io_write  (io_write),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .hl_out    (hl_out),
  .bc_out    (bc_out),
  .flags_out (flags_out),
  .mode_down (mode_down),
  .mode_rep  (mode_rep)
);

// File: tb/blk_io_seq_bench.sv
`timescale 1ns/1ps
module blk_io_seq_bench;
  localparam int EXTRA = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic        cmd_to_port = 1'b0, cmd_down = 1'b0, cmd_repeat = 1'b0;
  logic [15:0] cmd_hl = '0, cmd_bc = '0;
  logic        io_valid, io_write, io_ready = 1'b0;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata, io_rdata = '0;
  logic        mem_valid, mem_write, mem_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic        busy, done;
  logic [15:0] hl_out, bc_out;
  logic [7:0]  flags_out;

  always #2.5 clk = ~clk;

  blk_io_seq #(.EXTRA_CYCLES(EXTRA)) u_blk_io_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_to_port(cmd_to_port), .cmd_down(cmd_down), .cmd_repeat(cmd_repeat),
    .cmd_hl(cmd_hl), .cmd_bc(cmd_bc),
    .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .hl_out(hl_out), .bc_out(bc_out), .flags_out(flags_out)
  );

  typedef struct {
    logic        is_io;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    int          gap;
  } xfer_t;

  xfer_t exp_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  int    idle     = 0;
  logic  excl_bad = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] io_f(input logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'hA5;
  endfunction

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] + 8'h3C);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // Responder models and scoreboard monitor, all at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      io_ready  = lfsr[0] | lfsr[3];
      mem_ready = lfsr[1] | lfsr[5];
      io_rdata  = io_f(io_addr);
      mem_rdata = mem_f(mem_addr);
      if (io_valid && mem_valid) excl_bad = 1'b1;
      if ((io_valid && io_ready) || (mem_valid && mem_ready)) begin
        xfer_t got, e;
        got.is_io = io_valid;
        got.wr    = io_valid ? io_write : mem_write;
        got.addr  = io_valid ? io_addr : mem_addr;
        got.data  = io_valid ? (io_write ? io_wdata : io_rdata)
                             : (mem_write ? mem_wdata : mem_rdata);
        if (exp_q.size() == 0) begin
          chk("R2/R3 unexpected handshake", 1, 0);
        end else begin
          e = exp_q.pop_front();
          if (e.is_io ^ e.wr) begin
            chk("R2 kind", {got.is_io, got.wr}, {e.is_io, e.wr});
            chk("R2 addr", got.addr, e.addr);
            chk("R2 data", got.data, e.data);
          end else begin
            chk("R3 kind", {got.is_io, got.wr}, {e.is_io, e.wr});
            chk("R3 addr", got.addr, e.addr);
            chk("R3 data", got.data, e.data);
          end
          if (e.gap >= 0) chk("R7 quiet cycles", idle, e.gap);
        end
        idle = 0;
      end else if (!io_valid && !mem_valid) begin
        idle++;
      end
    end
  end

  task automatic run_cmd(input logic to_port, input logic down, input logic rep,
                         input logic [15:0] hl, input logic [15:0] bc,
                         input logic intrude);
    logic [7:0]  b = bc[15:8];
    logic [7:0]  c = bc[7:0];
    logic [15:0] h = hl;
    int          n = rep ? ((b == 8'd0) ? 256 : int'(b)) : 1;
    logic [7:0]  fl;
    for (int k = 0; k < n; k++) begin
      xfer_t x;
      int g = (k == 0) ? -1 : EXTRA;
      if (!to_port) begin
        x = '{1'b1, 1'b0, {b, c}, io_f({b, c}), g};
        exp_q.push_back(x);
        x = '{1'b0, 1'b1, h, io_f({b, c}), 0};
        exp_q.push_back(x);
        h = down ? h - 16'd1 : h + 16'd1;
        b = b - 8'd1;
      end else begin
        logic [7:0] d = mem_f(h);
        x = '{1'b0, 1'b0, h, d, g};
        exp_q.push_back(x);
        h = down ? h - 16'd1 : h + 16'd1;
        b = b - 8'd1;
        x = '{1'b1, 1'b1, {b, c}, d, 0};
        exp_q.push_back(x);
      end
    end
    fl = 8'h02 | ((b == 8'd0) ? 8'h40 : 8'h00);
    excl_bad = 1'b0;
    @(negedge clk);
    cmd_to_port = to_port; cmd_down = down; cmd_repeat = rep;
    cmd_hl = hl; cmd_bc = bc; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (intrude) begin
      // R1: a command offered while busy must leave the run untouched
      cmd_to_port = ~to_port; cmd_down = ~down; cmd_repeat = 1'b0;
      cmd_hl = 16'h5555; cmd_bc = 16'h0101; cmd_valid = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 ready low while busy", cmd_ready, 0);
      cmd_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    chk("R4 final HL", hl_out, h);
    chk("R5 final BC", bc_out, {b, c});
    chk("R6 flags", flags_out, fl);
    chk("R9 all transfers done", exp_q.size(), 0);
    chk("R10 strobes exclusive", excl_bad, 0);
    @(negedge clk);
    chk("R9 done is a pulse", done, 0);
    exp_q.delete();
  endtask

  initial begin
    #(150000 * 5.0);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset ready", cmd_ready, 1);
    chk("R1 reset busy", busy, 0);
    chk("R10 reset io strobe", io_valid, 0);
    chk("R10 reset mem strobe", mem_valid, 0);
    chk("R9 reset done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_cmd(1'b0, 1'b0, 1'b0, 16'h1000, 16'h0312, 1'b0); // R2 single in, up
    run_cmd(1'b1, 1'b1, 1'b0, 16'h2000, 16'h0177, 1'b0); // R3 single out, B to zero
    run_cmd(1'b0, 1'b0, 1'b1, 16'hFFFE, 16'h0405, 1'b0); // R4 HL wraps upward
    run_cmd(1'b1, 1'b1, 1'b1, 16'h0001, 16'h0380, 1'b0); // R4 HL wraps downward
    run_cmd(1'b0, 1'b0, 1'b1, 16'h4000, 16'h00C3, 1'b0); // R5 256 transfers
    run_cmd(1'b1, 1'b0, 1'b1, 16'h3000, 16'h0333, 1'b1); // R1 intruding command
    run_cmd(1'b0, 1'b1, 1'b0, 16'h0800, 16'h0009, 1'b0); // R9 single from B=0
    run_cmd(1'b1, 1'b0, 1'b1, 16'h0900, 16'h0001, 1'b0); // R6 repeat of one
    report();
  end
endmodule